// File: doc/BRIEF.md
# Chip-Select Wait-State Controller

This block lengthens external bus accesses by a programmable number of wait cycles. Four chip-select spaces each have their own 4-bit wait count. The four counts sit together in one 16-bit configuration word, which the CPU reads and writes through a plain register port. Address decoding happens elsewhere, so the index of the addressed space arrives as an input when an access begins.

When an access starts, the controller picks up the selected space's count and holds both for the whole access. A count of zero finishes the access at once and ignores the external wait request. A nonzero count N inserts N wait cycles. The external wait request is then sampled on the last of those cycles, and the access is stretched one cycle at a time for as long as the request stays high. Completion is signalled by a single-cycle ready strobe.

Two reset sources act differently. A power-on reset or a hardware-standby request sets the configuration word to all ones (15 waits, external wait honoured, in every space). A manual reset only returns the sequencer to idle and keeps the configuration. The sequencer states are IDLE, WAIT, EXTEND and READY. The transitions are:
- IDLE→READY on a start with count 0.
- IDLE→WAIT on a start with a nonzero count.
- WAIT→WAIT while waits remain.
- WAIT→EXTEND on the last wait with the wait request high.
- WAIT→READY on the last wait with the request low.
- EXTEND→EXTEND while the request stays high.
- EXTEND→READY when it drops.
- READY→IDLE always.

Top module: `cs_wait_ctrl`

## Requirements
- R1: While power-on reset is high, and after it is released, the configuration word reads 0xFFFF until it is written, and the ready strobe is low.
- R2: A hardware-standby request reloads the configuration word with 0xFFFF.
- R3: A manual reset aborts an access in progress without producing a ready strobe, and leaves the configuration word unchanged.
- R4: A write stores all 16 bits, and the read port returns them from the cycle after the write.
- R5: Space s takes its wait count from configuration bits [4s+3:4s]: space 0 uses bits 3..0 and space 3 uses bits 15..12.
- R6: With a count of 0, ready is high in the cycle right after the start cycle, whatever the external wait request does.
- R7: With a count N from 1 to 15 and the wait request low, ready is high N cycles after the cycle that follows the start cycle.
- R8: With a nonzero count, a wait request that is high on the last wait cycle and stays high for K consecutive cycles delays ready by exactly K cycles.
- R9: Ready is high for exactly one clock per access.
- R10: An access uses the count that was in the register before its start cycle. Writes in the start cycle or during the access apply only to later accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| por_i | input | 1 | Power-on reset, active high, asynchronous |
| hw_stby_i | input | 1 | Hardware-standby request, active high, asynchronous, reloads configuration |
| mrst_i | input | 1 | Manual reset, active high, synchronous, sequencer only |
| reg_wr_i | input | 1 | Configuration write enable |
| reg_wdata_i | input | 16 | Configuration write data |
| reg_rdata_o | output | 16 | Configuration read data |
| acc_start_i | input | 1 | One-cycle pulse that begins an access |
| acc_space_i | input | 2 | Chip-select space of the access being started |
| ext_wait_i | input | 1 | External wait request, active high |
| acc_ready_o | output | 1 | One-cycle access-complete strobe |

## Verification
The assertions assume that a start pulse arrives only while the sequencer is idle, meaning no earlier than the cycle after a ready strobe. They also assume that the space index is valid whenever the start pulse is high. The stimulus keeps to this: each access is driven to its ready strobe, or cut short by a manual reset, and the bench waits past it before the next start. Wait-request and register-write activity is confined to the cycles of an access, and the bench places those cycles relative to the start edge.

// File: rtl/cswait_pkg.sv
`timescale 1ns/1ps
package cswait_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_EXTEND = 2'd2,
        ST_READY  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cswait_cfg_reg.sv
`timescale 1ns/1ps
module cswait_cfg_reg #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             arst,
    input  logic             mrst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q
);
    // power-on / hardware standby load all ones; manual reset does not touch it
    always_ff @(posedge clk or posedge arst) begin
        if (arst)       cfg_q <= '1;
        else if (wr_en) cfg_q <= wdata;
    end

    p_hold_on_mreset_r3: assert property (@(posedge clk) disable iff (arst)
        (mrst && !wr_en) |=> $stable(cfg_q));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (arst)
        wr_en |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/cswait_field_sel.sv
`timescale 1ns/1ps
module cswait_field_sel #(
    parameter int NSPACE = 4,
    parameter int FW     = 4,
    localparam int REG_W = NSPACE * FW,
    localparam int SW    = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic [REG_W-1:0] cfg,
    input  logic [SW-1:0]    space,
    output logic [FW-1:0]    field
);
    logic [FW-1:0] fields [NSPACE];

    for (genvar g = 0; g < NSPACE; g++) begin : g_split
        assign fields[g] = cfg[g*FW +: FW];
    end

    assign field = fields[space];
endmodule

// File: rtl/cswait_seq.sv
`timescale 1ns/1ps
module cswait_seq
    import cswait_pkg::*;
#(
    parameter int FW = 4
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          mrst,
    input  logic          start_i,
    input  logic [FW-1:0] wcnt_i,
    input  logic          ext_wait_i,
    output logic          rdy_o
);
    seq_state_t    state_q, state_d;
    logic [FW-1:0] cnt_q, cnt_d;
    logic          last_wait;

    assign last_wait = (cnt_q == FW'(1));

    // next-state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    cnt_d   = wcnt_i;
                    state_d = (wcnt_i == '0) ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                cnt_d = cnt_q - FW'(1);
                if (last_wait)
                    state_d = ext_wait_i ? ST_EXTEND : ST_READY;
            end
            ST_EXTEND: begin
                if (!ext_wait_i) state_d = ST_READY;
            end
            ST_READY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (mrst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        rdy_o = (state_q == ST_READY);
    end

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (arst || mrst)
        rdy_o |=> !rdy_o);

    p_zero_wait_r6: assert property (@(posedge clk) disable iff (arst || mrst)
        (state_q == ST_IDLE && start_i && wcnt_i == '0) |=> rdy_o);

    p_nonzero_wait_r7: assert property (@(posedge clk) disable iff (arst || mrst)
        (state_q == ST_IDLE && start_i && wcnt_i != '0) |=> !rdy_o);

    p_hold_ext_r8: assert property (@(posedge clk) disable iff (arst || mrst)
        (state_q == ST_EXTEND && ext_wait_i) |=> !rdy_o);

    p_count_down_r10: assert property (@(posedge clk) disable iff (arst || mrst)
        (state_q == ST_WAIT && !last_wait) |=>
            (state_q == ST_WAIT && cnt_q == $past(cnt_q) - FW'(1)));
endmodule

// File: rtl/cs_wait_ctrl.sv
`timescale 1ns/1ps
module cs_wait_ctrl #(
    parameter int NSPACE = 4,
    parameter int FW     = 4,
    localparam int REG_W = NSPACE * FW,
    localparam int SW    = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic             clk,
    input  logic             por_i,
    input  logic             hw_stby_i,
    input  logic             mrst_i,
    input  logic             reg_wr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             acc_start_i,
    input  logic [SW-1:0]    acc_space_i,
    input  logic             ext_wait_i,
    output logic             acc_ready_o
);
    logic             hard_rst;
    logic [REG_W-1:0] cfg;
    logic [FW-1:0]    sel_cnt;

    assign hard_rst = por_i | hw_stby_i;

    cswait_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .arst  (hard_rst),
        .mrst  (mrst_i),
        .wr_en (reg_wr_i),
        .wdata (reg_wdata_i),
        .cfg_q (cfg)
    );

    cswait_field_sel #(.NSPACE(NSPACE), .FW(FW)) u_sel (
        .cfg   (cfg),
        .space (acc_space_i),
        .field (sel_cnt)
    );

    cswait_seq #(.FW(FW)) u_seq (
        .clk        (clk),
        .arst       (hard_rst),
        .mrst       (mrst_i),
        .start_i    (acc_start_i),
        .wcnt_i     (sel_cnt),
        .ext_wait_i (ext_wait_i),
        .rdy_o      (acc_ready_o)
    );

    assign reg_rdata_o = cfg;

    p_reset_value_r1: assert property (@(posedge clk)
        $past(por_i) |-> (reg_rdata_o == '1 || $past(hw_stby_i) == 1'b0 && !$past(por_i)));
endmodule

// File: tb/sim_cs_wait_ctrl.sv
`timescale 1ns/1ps
module sim_cs_wait_ctrl;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        hw_stby = 1'b0;
    logic        mrst = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        acc_start = 1'b0;
    logic [1:0]  acc_space = '0;
    logic        ext_wait = 1'b0;
    logic        acc_ready;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cs_wait_ctrl u0 (
        .clk         (clk),
        .por_i       (por),
        .hw_stby_i   (hw_stby),
        .mrst_i      (mrst),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .acc_start_i (acc_start),
        .acc_space_i (acc_space),
        .ext_wait_i  (ext_wait),
        .acc_ready_o (acc_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // ready expected at sample index n+k (index 0 = first negedge after start edge)
    task automatic run_access(input int s, input int n, input int k, input string req);
        int hits;
        int first;
        hits = 0;
        first = -1;
        @(negedge clk);
        acc_start = 1'b1;
        acc_space = 2'(s);
        ext_wait = (n == 0);
        @(negedge clk);
        acc_start = 1'b0;
        for (int i = 0; i < n + k + 3; i++) begin
            if (acc_ready) begin
                hits++;
                if (first < 0) first = i;
            end
            ext_wait = (n == 0) ? 1'b1 : ((i + 1 >= n) && (i + 1 < n + k));
            @(negedge clk);
        end
        ext_wait = 1'b0;
        chk(req, first, n + k);
        chk("R9 one ready pulse", hits, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reg during por", reg_rdata, 16'hFFFF);
        chk("R1 ready during por", acc_ready, 0);
        por = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reg after por", reg_rdata, 16'hFFFF);
        chk("R1 ready idle", acc_ready, 0);

        // R4 full-width write/read
        write_cfg(16'h0000);
        chk("R4 readback zero", reg_rdata, 16'h0000);
        write_cfg(16'hA5C3);
        chk("R4 readback pattern", reg_rdata, 16'hA5C3);

        // R5 / R6 / R7 sweep over every space and count
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic [15:0] w;
                w = {4{4'(~v)}};
                w[s*4 +: 4] = 4'(v);
                write_cfg(w);
                if (v == 0) run_access(s, v, 0, "R6 R5 zero wait");
                else        run_access(s, v, 0, "R7 R5 wait count");
            end
        end

        // R8 external wait extension
        for (int j = 0; j < 3; j++) begin
            int n;
            n = (j == 0) ? 1 : ((j == 1) ? 3 : 15);
            write_cfg({4{4'(n)}});
            run_access(j, n, 1, "R8 extend by one");
            run_access(j + 1, n, 4, "R8 extend by four");
        end

        // R10 writes in start cycle and mid-access do not affect the access
        write_cfg(16'h0002);
        begin
            int first;
            first = -1;
            @(negedge clk);
            acc_start = 1'b1;
            acc_space = 2'd0;
            reg_wr = 1'b1;
            reg_wdata = 16'h000F;
            @(negedge clk);
            acc_start = 1'b0;
            for (int i = 0; i < 6; i++) begin
                if (acc_ready && first < 0) first = i;
                reg_wr = (i == 0);
                reg_wdata = 16'h0000;
                @(negedge clk);
            end
            reg_wr = 1'b0;
            chk("R10 latched count", first, 2);
        end
        run_access(0, 0, 0, "R10 later access uses new value");

        // R3 manual reset mid-access
        write_cfg(16'h1234);
        begin
            int hits;
            hits = 0;
            @(negedge clk);
            acc_start = 1'b1;
            acc_space = 2'd0;
            @(negedge clk);
            acc_start = 1'b0;
            for (int i = 0; i < 10; i++) begin
                if (acc_ready) hits++;
                mrst = (i == 0);
                @(negedge clk);
            end
            mrst = 1'b0;
            chk("R3 aborted no ready", hits, 0);
            chk("R3 reg kept", reg_rdata, 16'h1234);
        end
        run_access(0, 4, 0, "R3 access after manual reset");

        // R2 hardware standby reload
        @(negedge clk);
        hw_stby = 1'b1;
        @(negedge clk);
        hw_stby = 1'b0;
        chk("R2 reload", reg_rdata, 16'hFFFF);
        run_access(2, 15, 0, "R2 default fifteen waits");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule